// File: doc/BRIEF.md
# Instruction Prefetch Queue with Deferred Fetch-Fault Tags

This block sits between the instruction-fetch bus interface and the instruction decoder. Every fetched 16-bit word enters a small circular queue together with a one-bit tag recording whether its bus cycle ended in an error. The error is not reported when the fetch completes. It stays with the word and only matters if the decoder actually tries to use that word.

The decoder shows the oldest words of the queue through a fixed window. It states how many words the next instruction occupies (the opword plus zero to two extension words) and pulses a consume request to retire them. Once every word the decoder asked for is present, the block raises a fault line to the exception logic if any of those words carries an error tag. A faulting instruction cannot retire, so the queue does not change and nothing downstream is updated. A change-of-flow input empties the queue in one cycle. Tagged words that a redirect discards therefore never cause an exception.

Top module: `ifq_fault_defer`

## Requirements
- R1: After a synchronous active-low reset, `avail_o` is 0, `ready_o` and `fault_o` are low, and `fetch_ready_o` is high.
- R2: A fetch is stored when `fetch_valid_i` and `fetch_ready_o` are high and `flush_i` is low. Stored words keep arrival order, and `avail_o` rises by one on the next cycle when nothing is consumed.
- R3: `fetch_ready_o` is low exactly when `avail_o` equals the depth (4). A word offered while the queue is full is not stored.
- R4: Bits [16k+15:16k] of `words_o` show the k-th oldest stored word for k = 0..2, and show zero when fewer than k+1 words are stored.
- R5: The effective need is `need_i` for codes 1..3, and code 0 counts as 1. `ready_o` is high exactly when `avail_o` is at least the effective need.
- R6: A tagged word raises no fault while it lies outside the first effective-need words or while `ready_o` is low. A tag on the oldest word raises `fault_o` once `ready_o` is high.
- R7: `fault_o` is also raised when the tag is on any extension word (positions 1..effective need−1) and the oldest word is clean.
- R8: When `consume_i` and `ready_o` are high and `fault_o` and `flush_i` are low, the effective-need oldest words are removed on the next cycle.
- R9: `consume_i` while `fault_o` is high has no effect: the window contents and the count stay the same.
- R10: `flush_i` empties the queue on the next cycle and discards tagged words without a fault. A fetch or consume presented in the same cycle is ignored.
- R11: A store and a removal in the same cycle change `avail_o` by +1 minus the effective need.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_i | input | 1 | Change of flow: discard all entries |
| fetch_valid_i | input | 1 | Fetched word offered |
| fetch_data_i | input | 16 | Fetched instruction word |
| fetch_err_i | input | 1 | Bus error on this fetch |
| fetch_ready_o | output | 1 | Queue can accept a word |
| need_i | input | 2 | Words the next instruction needs (0 treated as 1) |
| consume_i | input | 1 | Decoder retires the needed words |
| words_o | output | 48 | Three oldest words, oldest in the low slot |
| avail_o | output | 3 | Number of stored words |
| ready_o | output | 1 | All needed words present |
| fault_o | output | 1 | A needed word carries a fetch error |

## Verification
Storing a new word and retiring older ones can fall in the same cycle. So can a redirect and an incoming fetch, and a consume request and a pending fault. The bench sweeps every tag pattern across a full queue for each need value and offers a consume with the fault raised and without it. It then runs a long stretch of random fetch, consume, need and flush traffic in which these coincide often. Each cycle is judged against a bench-side ordered word list that applies removal before storage and drops everything on a flush. The count, window, ready and fault outputs are compared before every edge.

// File: rtl/ifq_pkg.sv
// Package: shared helpers for the prefetch queue.
// Assumes need codes are unsigned; code 0 is treated as a one-word need.
package ifq_pkg;

    // Map a raw need code onto the number of words actually required.
    function automatic int unsigned ifq_eff_need(input int unsigned code,
                                                 input int unsigned max_words);
        int unsigned r;
        r = (code == 0) ? 1 : code;
        if (r > max_words) r = max_words;
        return r;
    endfunction

endpackage

// File: rtl/ifq_store.sv
// Module: circular storage of fetched words and their error tags.
// Assumes DEPTH is a power of two, so the pointers wrap naturally, and
// the caller never pops more words than are stored.
module ifq_store #(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 4,
    parameter int NEED_W = 2,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush,
    input  logic                    push,
    input  logic [WORD_W-1:0]       push_word,
    input  logic                    push_err,
    input  logic                    pop,
    input  logic [NEED_W-1:0]       pop_n,
    output logic [CNT_W-1:0]        count,
    output logic [PTR_W-1:0]        rd_ptr,
    output logic [DEPTH*WORD_W-1:0] slot_words,
    output logic [DEPTH-1:0]        slot_errs
);

    logic [WORD_W-1:0] mem_word [DEPTH];
    logic              mem_err  [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [CNT_W-1:0]  count_next;

    // Work out the occupancy after this cycle's removal and store.
    always_comb begin
        count_next = count;
        if (pop)  count_next = count_next - CNT_W'(pop_n);
        if (push) count_next = count_next + CNT_W'(1);
    end

    // Keep the pointers and occupancy; a flush rewinds everything at once.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + PTR_W'(1);
            if (pop)  rd_ptr <= rd_ptr + PTR_W'(pop_n);
            count <= count_next;
        end
    end

    // Write the incoming word and its tag into the slot at the write pointer.
    always_ff @(posedge clk) begin
        if (push) begin
            mem_word[wr_ptr] <= push_word;
            mem_err[wr_ptr]  <= push_err;
        end
    end

    // Flatten the slots so the window logic can index them.
    generate
        for (genvar s = 0; s < DEPTH; s++) begin : g_flat
            assign slot_words[s*WORD_W +: WORD_W] = mem_word[s];
            assign slot_errs[s]                   = mem_err[s];
        end
    endgenerate

endmodule

// File: rtl/ifq_window.sv
// Module: presents the WIN oldest stored words and their tags in age order.
// Assumes WIN <= DEPTH; positions beyond the occupancy read as zero / clean.
module ifq_window #(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 4,
    parameter int WIN    = 3,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH*WORD_W-1:0] slot_words,
    input  logic [DEPTH-1:0]        slot_errs,
    input  logic [PTR_W-1:0]        rd_ptr,
    input  logic [CNT_W-1:0]        count,
    output logic [WIN*WORD_W-1:0]   win_words,
    output logic [WIN-1:0]          win_errs
);

    generate
        for (genvar k = 0; k < WIN; k++) begin : g_pos
            logic [PTR_W-1:0] idx;
            logic             live;
            // Select the slot k places after the oldest, masked by occupancy.
            always_comb begin
                idx  = rd_ptr + PTR_W'(k);
                live = (CNT_W'(k) < count);
                win_words[k*WORD_W +: WORD_W] =
                    live ? slot_words[idx*WORD_W +: WORD_W] : '0;
                win_errs[k] = live & slot_errs[idx];
            end
        end
    endgenerate

endmodule

// File: rtl/ifq_fault_eval.sv
// Module: decides whether the next instruction is complete and faulted.
// Assumes window tags are already masked to stored words only.
module ifq_fault_eval #(
    parameter int DEPTH  = 4,
    parameter int WIN    = 3,
    parameter int NEED_W = 2,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [NEED_W-1:0] need,
    input  logic [CNT_W-1:0]  count,
    input  logic [WIN-1:0]    win_errs,
    output logic [NEED_W-1:0] eff_need,
    output logic              ready,
    output logic              fault
);
    import ifq_pkg::*;

    logic [WIN-1:0] in_need;

    // Turn the raw need code into a word count.
    always_comb begin
        eff_need = NEED_W'(ifq_eff_need(int'(need), WIN));
    end

    // Mark the window positions that belong to the next instruction.
    generate
        for (genvar k = 0; k < WIN; k++) begin : g_mask
            assign in_need[k] = (NEED_W'(k) < eff_need);
        end
    endgenerate

    // Report the fault only once every needed word has arrived.
    always_comb begin
        ready = (count >= CNT_W'(eff_need));
        fault = ready & (|(win_errs & in_need));
    end

endmodule

// File: rtl/ifq_fault_defer.sv
// Module: instruction prefetch queue whose bus-error tags are reported only
// when the decoder tries to use a tagged word.
// Assumes the decoder holds need_i steady while it waits for ready_o, and
// that a change of flow is a single-cycle flush_i pulse.
module ifq_fault_defer #(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 4,
    parameter int WIN    = 3,
    localparam int NEED_W = $clog2(WIN + 1),
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush_i,
    input  logic                  fetch_valid_i,
    input  logic [WORD_W-1:0]     fetch_data_i,
    input  logic                  fetch_err_i,
    output logic                  fetch_ready_o,
    input  logic [NEED_W-1:0]     need_i,
    input  logic                  consume_i,
    output logic [WIN*WORD_W-1:0] words_o,
    output logic [CNT_W-1:0]      avail_o,
    output logic                  ready_o,
    output logic                  fault_o
);

    logic [CNT_W-1:0]        count;
    logic [PTR_W-1:0]        rd_ptr;
    logic [DEPTH*WORD_W-1:0] slot_words;
    logic [DEPTH-1:0]        slot_errs;
    logic [WIN-1:0]          win_errs;
    logic [NEED_W-1:0]       eff_need;
    logic                    ready, fault, push, pop;

    // Accept a word when there is room and no redirect; retire only clean,
    // complete instructions so a faulting one leaves the queue untouched.
    always_comb begin
        fetch_ready_o = (count != CNT_W'(DEPTH));
        push          = fetch_valid_i & fetch_ready_o & ~flush_i;
        pop           = consume_i & ready & ~fault & ~flush_i;
    end

    ifq_store #(.WORD_W(WORD_W), .DEPTH(DEPTH), .NEED_W(NEED_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush_i),
        .push       (push),
        .push_word  (fetch_data_i),
        .push_err   (fetch_err_i),
        .pop        (pop),
        .pop_n      (eff_need),
        .count      (count),
        .rd_ptr     (rd_ptr),
        .slot_words (slot_words),
        .slot_errs  (slot_errs)
    );

    ifq_window #(.WORD_W(WORD_W), .DEPTH(DEPTH), .WIN(WIN)) u_window (
        .slot_words (slot_words),
        .slot_errs  (slot_errs),
        .rd_ptr     (rd_ptr),
        .count      (count),
        .win_words  (words_o),
        .win_errs   (win_errs)
    );

    ifq_fault_eval #(.DEPTH(DEPTH), .WIN(WIN), .NEED_W(NEED_W)) u_eval (
        .need     (need_i),
        .count    (count),
        .win_errs (win_errs),
        .eff_need (eff_need),
        .ready    (ready),
        .fault    (fault)
    );

    // Drive the status outputs from the internal decisions.
    always_comb begin
        avail_o = count;
        ready_o = ready;
        fault_o = fault;
    end

endmodule

// File: rtl/ifq_fault_defer_chk.sv
// Module: assertion checker for the prefetch queue, attached by bind.
// Assumes it observes only the top-level ports.
module ifq_fault_defer_chk #(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 4,
    parameter int WIN    = 3,
    localparam int NEED_W = $clog2(WIN + 1),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  flush_i,
    input logic                  fetch_valid_i,
    input logic                  fetch_ready_o,
    input logic [NEED_W-1:0]     need_i,
    input logic                  consume_i,
    input logic [WIN*WORD_W-1:0] words_o,
    input logic [CNT_W-1:0]      avail_o,
    input logic                  ready_o,
    input logic                  fault_o
);

    logic [CNT_W-1:0] eff;
    logic             push_seen;

    // Independent view of the need count and of an accepted fetch.
    always_comb begin
        eff = (need_i == '0) ? CNT_W'(1) : CNT_W'(need_i);
        push_seen = fetch_valid_i & fetch_ready_o & ~flush_i;
    end

    // R1: reset leaves the queue empty.
    a_r1_reset_empty: assert property (@(posedge clk)
        !rst_n |=> avail_o == '0);

    // R3: full queue refuses fetches, and occupancy never exceeds depth.
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (avail_o <= CNT_W'(DEPTH)) && ((avail_o == CNT_W'(DEPTH)) -> !fetch_ready_o));

    // R6: a fault is never reported for an incomplete instruction.
    a_r6_fault_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> ready_o);

    // R9: consume during a fault leaves the window and count untouched.
    a_r9_fault_blocks_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && consume_i && !flush_i && !push_seen)
        |=> ($stable(words_o) && $stable(avail_o)));

    // R10: a flush leaves nothing behind.
    a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (avail_o == '0 && !fault_o));

    // R8: a clean consume without a store removes the needed words.
    a_r8_pop_count: assert property (@(posedge clk) disable iff (!rst_n)
        (consume_i && ready_o && !fault_o && !flush_i && !push_seen)
        |=> avail_o == $past(avail_o) - $past(eff));

endmodule

bind ifq_fault_defer ifq_fault_defer_chk #(
    .WORD_W(WORD_W), .DEPTH(DEPTH), .WIN(WIN)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush_i       (flush_i),
    .fetch_valid_i (fetch_valid_i),
    .fetch_ready_o (fetch_ready_o),
    .need_i        (need_i),
    .consume_i     (consume_i),
    .words_o       (words_o),
    .avail_o       (avail_o),
    .ready_o       (ready_o),
    .fault_o       (fault_o)
);

// File: tb/ifq_fault_defer_tb.sv
`timescale 1ns/1ps
module ifq_fault_defer_tb;
    localparam int W = 16;
    localparam int D = 4;
    localparam int WIN = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush_i = 1'b0;
    logic          fetch_valid_i = 1'b0;
    logic [W-1:0]  fetch_data_i = '0;
    logic          fetch_err_i = 1'b0;
    logic [1:0]    need_i = 2'd1;
    logic          consume_i = 1'b0;
    logic          fetch_ready_o, ready_o, fault_o;
    logic [WIN*W-1:0] words_o;
    logic [2:0]    avail_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [W-1:0] qd[$];
    bit           qe[$];

    always #2.5 clk = ~clk;

    ifq_fault_defer u_dut (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
        .fetch_valid_i(fetch_valid_i), .fetch_data_i(fetch_data_i),
        .fetch_err_i(fetch_err_i), .fetch_ready_o(fetch_ready_o),
        .need_i(need_i), .consume_i(consume_i), .words_o(words_o),
        .avail_o(avail_o), .ready_o(ready_o), .fault_o(fault_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: drive at the falling edge, compare against the model,
    // then advance the model to the state after the coming rising edge.
    task automatic cyc(input bit fv, input logic [W-1:0] fd, input bit fe,
                       input int nd, input bit cons, input bit fl,
                       input string tag);
        int cnt, eff, first;
        bit mr, mf, push, pop;
        @(negedge clk);
        fetch_valid_i = fv; fetch_data_i = fd; fetch_err_i = fe;
        need_i = 2'(nd); consume_i = cons; flush_i = fl;
        #0.5;
        cnt = qd.size();
        eff = (nd == 0) ? 1 : nd;
        mr = (cnt >= eff);
        first = -1;
        for (int k = 0; k < eff && k < cnt; k++)
            if (qe[k] && first < 0) first = k;
        mf = mr && (first >= 0);
        chk(tag, int'(avail_o), cnt);
        chk("R3 fetch_ready", int'(fetch_ready_o), int'(cnt < D));
        chk("R5 ready", int'(ready_o), int'(mr));
        chk((mf && first > 0) ? "R7 fault" : "R6 fault", int'(fault_o), int'(mf));
        for (int k = 0; k < WIN; k++)
            chk("R4 window", int'(words_o[k*W +: W]), (k < cnt) ? int'(qd[k]) : 0);
        push = fv && (cnt < D) && !fl;
        pop = cons && mr && !mf && !fl;
        if (fl) begin
            qd.delete(); qe.delete();
        end else begin
            if (pop) for (int k = 0; k < eff; k++) begin
                void'(qd.pop_front()); void'(qe.pop_front());
            end
            if (push) begin
                qd.push_back(fd); qe.push_back(fe);
            end
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        string nxt;
        bit    pf;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 avail", int'(avail_o), 0);
        chk("R1 ready", int'(ready_o), 0);
        chk("R1 fault", int'(fault_o), 0);
        chk("R1 fetch_ready", int'(fetch_ready_o), 1);
        rst_n = 1'b1;
        cyc(0, '0, 0, 1, 0, 0, "R1 avail");

        // Sweep every tag pattern over a full queue for each need value.
        for (int nd = 1; nd <= 3; nd++) begin
            for (int pat = 0; pat < 16; pat++) begin
                cyc(0, '0, 0, nd, 0, 1, "R10 avail");
                for (int i = 0; i < D; i++)
                    cyc(1, 16'(nd*4096 + pat*16 + i), pat[i], nd, 0, 0, "R2 avail");
                // R3: offered while full, must not be stored
                cyc(1, 16'hDEAD, 1, nd, 0, 0, "R2 avail");
                pf = 0;
                for (int k = 0; k < nd; k++) if (pat[k]) pf = 1;
                nxt = pf ? "R9 avail" : "R8 avail";
                cyc(0, '0, 0, nd, 1, 0, "R3 avail");
                cyc(0, '0, 0, nd, 1, 0, nxt);
                cyc(1, 16'h0F0F, 0, nd, 0, 0, "R8 avail");
                cyc(1, 16'hBEEF, 1, nd, 1, 1, "R11 avail");
                cyc(0, '0, 0, nd, 1, 0, "R10 avail");
            end
        end

        // Need code 0 behaves as a one-word need (R5).
        cyc(1, 16'h1234, 0, 0, 0, 0, "R10 avail");
        cyc(0, '0, 0, 0, 1, 0, "R2 avail");
        cyc(0, '0, 0, 0, 0, 0, "R5 avail");

        // Random traffic where stores, removals, faults and flushes coincide.
        for (int n = 0; n < 3000; n++) begin
            cyc(($urandom % 4) != 0, 16'($urandom), ($urandom % 6) == 0,
                int'($urandom % 4), ($urandom % 2) == 1, ($urandom % 20) == 0,
                "R11 avail");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule